// File: doc/BRIEF.md
# Prescaled Base Counter with Match and Pin Reset

This block is the time base of a waveform-generation timer unit. A 16-bit counter advances on ticks from a programmable prescaler. It has three counting modes: plain increment, increment or decrement steered by a direction input, and quadrature decoding of two phase inputs. A run bit gates all counting. Two optional sources clear the counter. One is a match against compare value 0, which clears the counter two ticks after the match. The other is a low level on an external pin.

Software programs the block through a single write port. The port has three targets: the divider (address 0), the control word (address 1) and the compare value (address 2). Writes to address 3 are dropped. The counter value and a one-cycle match pulse drive the output channels that sit beside this block.

Top module: `base_timer`

## Requirements
- R1: After reset the count output is 0, the match output is 0, and the divider, control word and compare value are all 0, so the counter stays stopped.
- R2: Control bit 0 (run) at 0 clears the counter and the prescaler on the next clock. At 1, counting is enabled.
- R3: The divider (address 0, data bits 7:0, value n) makes the counter step once every n+1 prescaler events. In the increment and up/down modes an event occurs on every clock.
- R4: In mode 00 (control bits 4:3) every tick adds 1, and the counter wraps from 0xFFFF to 0x0000.
- R5: In mode 01 a tick adds 1 when the `updown` input is 1 and subtracts 1 when it is 0. The input is sampled in the tick cycle. Decrementing from 0x0000 gives 0xFFFF.
- R6: In mode 10 each single-phase change of the inputs is one prescaler event. The direction is up when A leads B, following the cycle 00→10→11→01→00 on (A,B), and down for the reverse order. A change in which A and B flip together is ignored. Both phases pass through two synchronizing flops, so a change shows in the count three clocks later when the divider is 0.
- R7: Mode code 11 behaves exactly as increment.
- R8: The match output is high for one clock when a counting step has just made the count equal to the compare value (address 2). This happens whether or not the match reset is enabled. A clear never raises it.
- R9: With control bit 1 (match reset enable) at 1, the first tick after a match steps the counter normally. The second tick loads 0 instead of stepping.
- R10: With control bit 1 at 0, a match leaves counting unaffected.
- R11: With control bit 2 (pin reset enable) at 1, `ext_rst_n` at 0 holds the counter and prescaler at 0. It takes effect two clocks after the pin is sampled low, through a two-flop synchronizer. With bit 2 at 0 the pin has no effect.
- R12: In mode 10 the divider also applies: only every (n+1)th quadrature event steps the counter, in that event's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 divider, 1 control, 2 compare |
| wr_data | input | 16 | Write data |
| updown | input | 1 | Direction in mode 01 (1 up, 0 down) |
| phase_a | input | 1 | Quadrature phase A |
| phase_b | input | 1 | Quadrature phase B |
| ext_rst_n | input | 1 | Active-low external counter clear |
| count | output | 16 | Counter value |
| match | output | 1 | One-cycle pulse when a step lands on the compare value |

## Verification
An off-by-one in the prescaler count moves every later step by whole clocks, and the cycle-by-cycle comparison catches it within one divider period. A wrong pending-reset state changes the period of the match-reset sequence, so the count differs from the model on the second tick after a match. A fault in quadrature decoding or synchronizer depth shows three clocks after the phase change, as a count that moves the wrong way or at the wrong clock. Pin-reset latency errors show within two clocks of the pin falling.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        MODE_INC  = 2'b00,
        MODE_UPDN = 2'b01,
        MODE_QUAD = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef struct packed {
        logic  run;
        logic  mrst_en;
        logic  prst_en;
        mode_e mode;
    } ctl_t;

    localparam logic [1:0] ADDR_DIV = 2'd0;
    localparam logic [1:0] ADDR_CTL = 2'd1;
    localparam logic [1:0] ADDR_CMP = 2'd2;
endpackage

// File: rtl/bt_sync2.sv
module bt_sync2 #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ev_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] ps_d, ps_q;

    always_comb begin
        tick_o = ev_i && (ps_q >= div_i);
        ps_d   = ps_q;
        if (clr_i)       ps_d = '0;
        else if (tick_o) ps_d = '0;
        else if (ev_i)   ps_d = ps_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    // R3
    ps_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !clr_i && !tick_o) |=> (ps_q == $past(ps_q) + 1'b1));
endmodule

// File: rtl/bt_quad_decoder.sv
module bt_quad_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic ev_o,
    output logic up_o
);
    logic [1:0] ab_sync;
    logic [1:0] prev_d, prev_q;
    logic       a_chg, b_chg;

    bt_sync2 #(.W(2), .RST_VAL(2'b00)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({a_i, b_i}),
        .q_o  (ab_sync)
    );

    always_comb begin
        prev_d = ab_sync;
        a_chg  = ab_sync[1] ^ prev_q[1];
        b_chg  = ab_sync[0] ^ prev_q[0];
        ev_o   = a_chg ^ b_chg;
        up_o   = (a_chg && (ab_sync[1] ^ ab_sync[0])) ||
                 (b_chg && !(ab_sync[1] ^ ab_sync[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= prev_d;
    end

    // R6
    double_flip_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_sync == ~prev_q) |-> !ev_o);
endmodule

// File: rtl/base_timer.sv
module base_timer #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             updown,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             ext_rst_n,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    import bt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        ctl_t             ctl;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       pend;
        logic             hit;
    } st_t;

    st_t st_d, st_q;

    logic             pin_s;
    logic             q_ev, q_up;
    logic             ev, up, tick, clr;
    logic [CNT_W-1:0] nxt;

    bt_sync2 #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ext_rst_n),
        .q_o  (pin_s)
    );

    bt_quad_decoder u_quad (
        .clk  (clk),
        .rst_n(rst_n),
        .a_i  (phase_a),
        .b_i  (phase_b),
        .ev_o (q_ev),
        .up_o (q_up)
    );

    bt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .ev_i  (ev),
        .div_i (st_q.div),
        .tick_o(tick)
    );

    always_comb begin
        clr = !st_q.ctl.run || (st_q.ctl.prst_en && !pin_s);
        ev  = (st_q.ctl.mode == MODE_QUAD) ? q_ev : 1'b1;
        case (st_q.ctl.mode)
            MODE_UPDN: up = updown;
            MODE_QUAD: up = q_up;
            default:   up = 1'b1;
        endcase
        nxt = up ? st_q.cnt + ONE : st_q.cnt - ONE;

        st_d     = st_q;
        st_d.hit = 1'b0;

        if (clr) begin
            st_d.cnt  = '0;
            st_d.pend = 2'd0;
        end else if (tick) begin
            if (st_q.pend == 2'd1) begin
                st_d.cnt  = '0;
                st_d.pend = 2'd0;
            end else begin
                st_d.cnt = nxt;
                st_d.hit = (nxt == st_q.cmp);
                if (st_q.pend == 2'd2)
                    st_d.pend = 2'd1;
                else if (st_q.ctl.mrst_en && nxt == st_q.cmp)
                    st_d.pend = 2'd2;
            end
        end

        if (wr_en) begin
            case (wr_addr)
                ADDR_DIV: st_d.div = wr_data[DIV_W-1:0];
                ADDR_CTL: st_d.ctl = '{run:     wr_data[0],
                                       mrst_en: wr_data[1],
                                       prst_en: wr_data[2],
                                       mode:    mode_e'(wr_data[4:3])};
                ADDR_CMP: st_d.cmp = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign match = st_q.hit;

    // R2
    stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.run |=> (count == '0));

    // R11
    pin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.prst_en && !pin_s) |=> (count == '0));

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && st_q.pend != 2'd1) |=>
        ((count == $past(count) + ONE) || (count == $past(count) - ONE)));

    // R8
    match_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(tick) && !$past(clr)));

    // R9
    delayed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && st_q.pend == 2'd1) |=> (count == '0 && !match));
endmodule

// File: tb/tb_base_timer.sv
module tb_base_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        updown = 1'b1;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic [15:0] count;
    logic        match;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    base_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .updown(updown), .phase_a(phase_a),
        .phase_b(phase_b), .ext_rst_n(ext_rst_n), .count(count), .match(match)
    );

    // behavioural reference
    int m_div, m_run, m_mre, m_pre, m_mode, m_cmp, m_cnt, m_ps, m_pend, m_hit;
    int a_h[3], b_h[3], pin_h[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_run = 0; m_mre = 0; m_pre = 0; m_mode = 0; m_cmp = 0;
            m_cnt = 0; m_ps = 0; m_pend = 0; m_hit = 0;
            foreach (a_h[i]) begin a_h[i] = 0; b_h[i] = 0; end
            pin_h[0] = 1; pin_h[1] = 1;
        end else begin
            bit ach, bch, qev, qup, ev, up, clear;
            ach = (a_h[1] != a_h[2]);
            bch = (b_h[1] != b_h[2]);
            qev = ach ^ bch;
            qup = (ach && a_h[1] != b_h[1]) || (bch && a_h[1] == b_h[1]);
            clear = (m_run == 0) || (m_pre != 0 && pin_h[1] == 0);
            ev = (m_mode == 2) ? qev : 1'b1;
            up = (m_mode == 1) ? updown : (m_mode == 2) ? qup : 1'b1;
            m_hit = 0;
            if (clear) begin
                m_cnt = 0; m_ps = 0; m_pend = 0;
            end else if (ev) begin
                if (m_ps >= m_div) begin
                    m_ps = 0;
                    if (m_pend == 1) begin
                        m_cnt = 0; m_pend = 0;
                    end else begin
                        m_cnt = (m_cnt + (up ? 1 : 65535)) % 65536;
                        m_hit = (m_cnt == m_cmp);
                        if (m_pend == 2) m_pend = 1;
                        else if (m_mre != 0 && m_hit != 0) m_pend = 2;
                    end
                end else m_ps = m_ps + 1;
            end
            a_h[2] = a_h[1]; a_h[1] = a_h[0]; a_h[0] = phase_a;
            b_h[2] = b_h[1]; b_h[1] = b_h[0]; b_h[0] = phase_b;
            pin_h[1] = pin_h[0]; pin_h[0] = ext_rst_n;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_div = wr_data[7:0];
                    2'd1: begin
                        m_run = wr_data[0]; m_mre = wr_data[1];
                        m_pre = wr_data[2]; m_mode = wr_data[4:3];
                        if (m_mode == 3) m_mode = 0;
                    end
                    2'd2: m_cmp = wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk({cur_req, " count"}, count, m_cnt);
            chk({cur_req, " match"}, match, m_hit);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] ctlw(int run, int mre, int pre, int mode);
        return 16'(run | (mre << 1) | (pre << 2) | (mode << 3));
    endfunction

    int qidx = 0;
    task automatic qstep(int dir, int hold);
        qidx = (qidx + (dir > 0 ? 1 : 3)) % 4;
        case (qidx)
            0: begin phase_a = 0; phase_b = 0; end
            1: begin phase_a = 1; phase_b = 0; end
            2: begin phase_a = 1; phase_b = 1; end
            default: begin phase_a = 0; phase_b = 1; end
        endcase
        idle(hold);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 count after reset", count, 0);
        chk("R1 match after reset", match, 0);
        idle(5);

        cur_req = "R3";
        wr(2'd0, 16'd2);
        wr(2'd1, ctlw(1, 0, 0, 0));
        idle(30);
        wr(2'd0, 16'd0);

        cur_req = "R2";
        wr(2'd1, ctlw(0, 0, 0, 0));
        idle(4);
        chk("R2 stopped count", count, 0);
        wr(2'd1, ctlw(1, 0, 0, 0));
        idle(6);

        cur_req = "R5";
        wr(2'd1, ctlw(0, 0, 0, 1));
        wr(2'd1, ctlw(1, 0, 0, 1));
        for (int i = 0; i < 40; i++) begin
            updown = ((i % 7) < 3);
            @(negedge clk);
        end

        cur_req = "R4";
        wr(2'd1, ctlw(0, 0, 0, 1));
        updown = 1'b0;
        wr(2'd1, ctlw(1, 0, 0, 1));
        idle(3);
        wr(2'd1, ctlw(1, 0, 0, 0));
        idle(6);
        updown = 1'b1;

        cur_req = "R7";
        wr(2'd1, ctlw(1, 0, 0, 3));
        idle(20);

        cur_req = "R8";
        wr(2'd2, 16'd20);
        wr(2'd1, ctlw(0, 0, 0, 0));
        wr(2'd1, ctlw(1, 0, 0, 0));
        idle(30);

        cur_req = "R10";
        idle(10);

        cur_req = "R9";
        wr(2'd2, 16'd5);
        wr(2'd0, 16'd1);
        wr(2'd1, ctlw(0, 1, 0, 0));
        wr(2'd1, ctlw(1, 1, 0, 0));
        idle(60);
        wr(2'd0, 16'd0);
        idle(25);
        wr(2'd1, ctlw(0, 0, 0, 0));
        wr(2'd2, 16'd1000);

        cur_req = "R11";
        wr(2'd1, ctlw(1, 0, 1, 0));
        idle(10);
        ext_rst_n = 1'b0; idle(3); ext_rst_n = 1'b1; idle(10);
        ext_rst_n = 1'b0; idle(1); ext_rst_n = 1'b1; idle(10);
        wr(2'd1, ctlw(1, 0, 0, 0));
        ext_rst_n = 1'b0; idle(5); ext_rst_n = 1'b1; idle(5);

        cur_req = "R6";
        wr(2'd1, ctlw(0, 0, 0, 2));
        wr(2'd1, ctlw(1, 0, 0, 2));
        for (int i = 0; i < 8; i++) qstep(1, 4);
        for (int i = 0; i < 5; i++) qstep(-1, 4);
        phase_a = ~phase_a; phase_b = ~phase_b; qidx = (qidx + 2) % 4; idle(6);
        for (int i = 0; i < 3; i++) qstep(1, 1);
        idle(4);

        cur_req = "R12";
        wr(2'd0, 16'd2);
        for (int i = 0; i < 12; i++) qstep(1, 3);
        for (int i = 0; i < 7; i++) qstep(-1, 2);
        idle(6);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule